// File: doc/BRIEF.md
# Prescaled Gated Period Timer

A 16-bit timer peripheral driven by a single system clock. Software configures it through a small register window holding a control word, the running count, the period value and a sticky event flag. Each increment of the counter is fed by a prescaler that divides a tick stream by 1, 8, 64 or 256. The tick stream comes from the system clock itself, from the system clock qualified by a gate pin, or from rising edges on an external count pin. The external pin can be taken through a two-stage synchronizer or through a shorter single-register sampling path.

When an increment finds the count equal to the period value, the counter returns to zero and the event flag is raised. In gated mode the flag instead marks the end of a gate pulse, which suits pulse-width measurement. Every register can be written directly or modified atomically through alias addresses that clear, set or invert only the bits written as one.

Top module: `pgt_top`

## Requirements
- R1: After a synchronous reset every register reads zero, `rd_data` is zero and `evt_flag` is low.
- R2: A write uses `wr_addr[3:2]` as register select (0 control, 1 count, 2 period, 3 flag in bit 0) and `wr_addr[1:0]` as operation (0 plain write, 1 clear the bits written as 1, 2 set them, 3 invert them). `rd_sel` picks the register read, and `rd_data` shows it one cycle later. Only control bits 15, 7, 5, 4, 2 and 1 are stored, and the other control bits read as zero.
- R3: While control bit 15 (enable) is 0 the count does not change except by a register write, and no event is raised.
- R4: With bit 1 = 0 and bit 7 = 0 the timer receives one tick per system clock cycle.
- R5: Control bits 5:4 select ticks per increment: 0 gives 1, 1 gives 8, 2 gives 64, 3 gives 256.
- R6: An increment that finds count equal to period loads zero and, outside gated mode, sets the flag. A period of 0 holds the count at 0.
- R7: A count above the period keeps incrementing to 0xFFFF and wraps to 0 without raising the flag.
- R8: With bit 1 = 1, each rising edge of `ext_clk_pin` is one tick. With bit 2 = 1 the pin goes through two synchronizer registers and the count changes on the third clock edge after the pin is sampled high. With bit 2 = 0 it changes on the second edge.
- R9: With bit 7 = 1 and bit 1 = 0, a tick occurs in each cycle where the registered `gate_pin` is high. The registered falling edge of the gate sets the flag, and period matches still clear the count but set no flag.
- R10: Bit 7 is ignored while bit 1 = 1: the gate pin neither blocks ticks nor sets the flag.
- R11: The flag stays set until software clears it. A hardware set in the same cycle as a software clear wins.
- R12: A control write that changes bits 5:4, or any count write, restarts the prescaler, so the next increment comes a full ratio of ticks later. A count write overrides an increment in the same cycle.
- R13: `evt_flag` equals the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Register select [3:2] and operation [1:0] |
| wr_data | input | 16 | Write data or bit mask |
| rd_sel | input | 2 | Register to read |
| rd_data | output | 16 | Registered read data |
| ext_clk_pin | input | 1 | External count pin |
| gate_pin | input | 1 | Gate input |
| evt_flag | output | 1 | Sticky timer event flag |

## Verification
The counting path is run in each source mode: free-running internal ticks with ratios 1 and 8, internal ticks gated by a randomly toggling gate, and external edges through both the synchronized and the short path (also with the gate bit set, where it must have no effect). Random alias writes to count, period and flag land between ticks, so these runs separate correct handling of write-versus-increment collisions, prescaler restarts and sticky-flag priority from designs that only count cleanly. Directed cases pin the absolute behaviour: a zero period, the wrap from 0xFFFE through 0xFFFF, the exact increment spacing at ratios 8 and 64, the tick count of a 20-cycle gate pulse, and the pipeline latency difference between the two external paths.

// File: rtl/pgt_pkg.sv
package pgt_pkg;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 2;
  localparam int OP_W   = 2;
  localparam int ADDR_W = SEL_W + OP_W;
  localparam int PS_W   = 8;

  localparam int B_EN   = 15;
  localparam int B_GATE = 7;
  localparam int B_PSHI = 5;
  localparam int B_PSLO = 4;
  localparam int B_SYNC = 2;
  localparam int B_SRC  = 1;

  typedef enum logic [OP_W-1:0] {
    OP_WRITE = 2'd0,
    OP_CLR   = 2'd1,
    OP_SET   = 2'd2,
    OP_INV   = 2'd3
  } wr_op_e;

  typedef enum logic [SEL_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_PERIOD = 2'd2,
    REG_FLAG   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pgt_regs.sv
module pgt_regs
  import pgt_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [DW-1:0]     cnt_i,
  input  logic              flag_set_i,
  output logic [DW-1:0]     ctrl_o,
  output logic [DW-1:0]     period_o,
  output logic              cnt_ld_o,
  output logic [DW-1:0]     cnt_ld_val_o,
  output logic              ps_clr_o,
  output logic              flag_o,
  output logic [DW-1:0]     rd_data_o
);
  localparam logic [DW-1:0] CTRL_MASK = DW'((1 << B_EN) | (1 << B_GATE) | (3 << B_PSLO)
                                           | (1 << B_SYNC) | (1 << B_SRC));

  function automatic logic [DW-1:0] apply_op(input wr_op_e op, input logic [DW-1:0] cur,
                                             input logic [DW-1:0] wd);
    case (op)
      OP_WRITE: return wd;
      OP_CLR:   return cur & ~wd;
      OP_SET:   return cur | wd;
      default:  return cur ^ wd;
    endcase
  endfunction

  reg_sel_e        sel;
  wr_op_e          op;
  logic [DW-1:0]   ctrl_q, period_q, ctrl_nxt;
  logic            flag_q, flag_sw;
  logic            wr_ctrl, wr_cnt, wr_per, wr_flag;

  assign sel     = reg_sel_e'(wr_addr[ADDR_W-1 -: SEL_W]);
  assign op      = wr_op_e'(wr_addr[OP_W-1:0]);
  assign wr_ctrl = wr_en && (sel == REG_CTRL);
  assign wr_cnt  = wr_en && (sel == REG_COUNT);
  assign wr_per  = wr_en && (sel == REG_PERIOD);
  assign wr_flag = wr_en && (sel == REG_FLAG);

  assign ctrl_nxt = apply_op(op, ctrl_q, wr_data) & CTRL_MASK;

  always_comb begin
    case (op)
      OP_WRITE: flag_sw = wr_data[0];
      OP_CLR:   flag_sw = flag_q & ~wr_data[0];
      OP_SET:   flag_sw = flag_q | wr_data[0];
      default:  flag_sw = flag_q ^ wr_data[0];
    endcase
  end

  assign cnt_ld_o     = wr_cnt;
  assign cnt_ld_val_o = apply_op(op, cnt_i, wr_data);
  assign ps_clr_o     = wr_cnt ||
                        (wr_ctrl && (ctrl_nxt[B_PSHI:B_PSLO] != ctrl_q[B_PSHI:B_PSLO]));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      period_q  <= '0;
      flag_q    <= 1'b0;
      rd_data_o <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_nxt;
      if (wr_per)  period_q <= apply_op(op, period_q, wr_data);
      if (flag_set_i)   flag_q <= 1'b1;
      else if (wr_flag) flag_q <= flag_sw;
      case (reg_sel_e'(rd_sel))
        REG_CTRL:   rd_data_o <= ctrl_q;
        REG_COUNT:  rd_data_o <= cnt_i;
        REG_PERIOD: rd_data_o <= period_q;
        default:    rd_data_o <= {{(DW-1){1'b0}}, flag_q};
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign period_o = period_q;
  assign flag_o   = flag_q;

  p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~CTRL_MASK) == '0);
  p_flag_set_r11: assert property (@(posedge clk) disable iff (rst)
    flag_set_i |=> flag_q);
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    flag_q && !flag_set_i && !wr_flag |=> flag_q);
endmodule

// File: rtl/pgt_tickgen.sv
module pgt_tickgen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic gate_en_i,
  input  logic sync_i,
  input  logic src_ext_i,
  input  logic ext_pin,
  input  logic gate_pin,
  output logic tick_o,
  output logic gate_fall_o,
  output logic gated_mode_o
);
  logic [SYNC_STAGES:0] sync_sh;
  logic [1:0]           async_sh;
  logic [1:0]           gate_sh;
  logic                 rise_sync, rise_async, ext_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_sh  <= '0;
      async_sh <= '0;
      gate_sh  <= '0;
    end else begin
      sync_sh  <= {sync_sh[SYNC_STAGES-1:0], ext_pin};
      async_sh <= {async_sh[0], ext_pin};
      gate_sh  <= {gate_sh[0], gate_pin};
    end
  end

  assign rise_sync    = sync_sh[SYNC_STAGES-1] & ~sync_sh[SYNC_STAGES];
  assign rise_async   = async_sh[0] & ~async_sh[1];
  assign ext_tick     = sync_i ? rise_sync : rise_async;
  assign gated_mode_o = gate_en_i & ~src_ext_i;

  always_comb begin
    if (!en_i)             tick_o = 1'b0;
    else if (src_ext_i)    tick_o = ext_tick;
    else if (gated_mode_o) tick_o = gate_sh[0];
    else                   tick_o = 1'b1;
  end

  assign gate_fall_o = en_i & gated_mode_o & gate_sh[1] & ~gate_sh[0];

  p_idle_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !en_i |-> !tick_o && !gate_fall_o);
  p_ext_no_gate_r10: assert property (@(posedge clk) disable iff (rst)
    src_ext_i |-> !gate_fall_o);
endmodule

// File: rtl/pgt_prescale.sv
module pgt_prescale
  import pgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ratio_sel,
  input  logic       tick,
  input  logic       clr,
  output logic       inc_o
);
  logic [PS_W-1:0] ps_q, term;
  logic            hit;

  always_comb begin
    if (ratio_sel == 2'd3) term = {PS_W{1'b1}};
    else                   term = PS_W'((1 << (3 * int'(ratio_sel))) - 1);
  end

  assign hit   = (ps_q == term);
  assign inc_o = tick & hit & ~clr;

  always_ff @(posedge clk) begin
    if (rst)       ps_q <= '0;
    else if (clr)  ps_q <= '0;
    else if (tick) ps_q <= hit ? '0 : ps_q + 1'b1;
  end

  p_ps_bound_r5: assert property (@(posedge clk) disable iff (rst)
    ps_q <= term);
  p_inc_needs_tick_r5: assert property (@(posedge clk) disable iff (rst)
    inc_o |-> tick);
endmodule

// File: rtl/pgt_counter.sv
module pgt_counter #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic [DW-1:0] period,
  output logic [DW-1:0] cnt_o,
  output logic          match_o
);
  logic [DW-1:0] cnt_q;
  logic          at_period;

  assign at_period = (cnt_q == period);
  assign match_o   = inc & ~ld & at_period;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (ld)  cnt_q <= ld_val;
    else if (inc) cnt_q <= at_period ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
    inc && !ld && (cnt_q != period) |=> cnt_q == DW'($past(cnt_q) + 1'b1));
  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (rst)
    inc && !ld && (cnt_q == period) |=> cnt_q == '0);
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !inc && !ld |=> $stable(cnt_q));
  p_cnt_load_r12: assert property (@(posedge clk) disable iff (rst)
    ld |=> cnt_q == $past(ld_val));
endmodule

// File: rtl/pgt_top.sv
module pgt_top
  import pgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_clk_pin,
  input  logic              gate_pin,
  output logic              evt_flag
);
  logic [DATA_W-1:0] ctrl, period, cnt, cnt_ld_val;
  logic              cnt_ld, ps_clr, tick, gate_fall, gated_mode, inc, match, flag_set;

  pgt_regs #(.DW(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(rd_sel), .cnt_i(cnt), .flag_set_i(flag_set), .ctrl_o(ctrl),
    .period_o(period), .cnt_ld_o(cnt_ld), .cnt_ld_val_o(cnt_ld_val),
    .ps_clr_o(ps_clr), .flag_o(evt_flag), .rd_data_o(rd_data)
  );

  pgt_tickgen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .en_i(ctrl[B_EN]), .gate_en_i(ctrl[B_GATE]),
    .sync_i(ctrl[B_SYNC]), .src_ext_i(ctrl[B_SRC]), .ext_pin(ext_clk_pin),
    .gate_pin(gate_pin), .tick_o(tick), .gate_fall_o(gate_fall),
    .gated_mode_o(gated_mode)
  );

  pgt_prescale u_ps (
    .clk(clk), .rst(rst), .ratio_sel(ctrl[B_PSHI:B_PSLO]), .tick(tick),
    .clr(ps_clr), .inc_o(inc)
  );

  pgt_counter #(.DW(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(inc), .ld(cnt_ld), .ld_val(cnt_ld_val),
    .period(period), .cnt_o(cnt), .match_o(match)
  );

  assign flag_set = gated_mode ? gate_fall : match;

  p_gated_no_match_flag_r9: assert property (@(posedge clk) disable iff (rst)
    gated_mode && !gate_fall && !evt_flag && !(wr_en && wr_addr[3:2] == 2'd3) |=> !evt_flag);
endmodule

// File: tb/sim_pgt_top.sv
`timescale 1ns/1ps
module sim_pgt_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        ext_clk_pin = 1'b0;
  logic        gate_pin = 1'b0;
  logic        evt_flag;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  pgt_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ext_clk_pin(ext_clk_pin),
    .gate_pin(gate_pin), .evt_flag(evt_flag)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected behaviour built from the requirements
  function automatic logic [15:0] alias_f(input logic [1:0] op, input logic [15:0] cur,
                                          input logic [15:0] wd);
    case (op)
      2'd0: return wd;
      2'd1: return cur & ~wd;
      2'd2: return cur | wd;
      default: return cur ^ wd;
    endcase
  endfunction

  function automatic int ratio_f(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 8;
      2'd2: return 64;
      default: return 256;
    endcase
  endfunction

  logic [15:0] m_ctrl, m_cnt, m_per, m_rd;
  logic        m_flag;
  int          m_ps;
  logic [2:0]  m_s;
  logic [1:0]  m_a, m_g, m_rsel;

  always @(posedge clk) begin
    logic [1:0]  sel, op;
    logic [15:0] nctrl;
    logic        wc, wn, wp, wf, en, src, gm, tick, gfall, clr, hit, inc, match, fset;
    if (rst) begin
      m_ctrl <= '0; m_cnt <= '0; m_per <= '0; m_rd <= '0; m_flag <= 1'b0;
      m_ps <= 0; m_s <= '0; m_a <= '0; m_g <= '0; m_rsel <= '0;
    end else begin
      sel = wr_addr[3:2]; op = wr_addr[1:0];
      wc = wr_en && sel == 2'd0; wn = wr_en && sel == 2'd1;
      wp = wr_en && sel == 2'd2; wf = wr_en && sel == 2'd3;
      en = m_ctrl[15]; src = m_ctrl[1];
      gm = m_ctrl[7] & ~src;
      if (!en) tick = 1'b0;
      else if (src) tick = m_ctrl[2] ? (m_s[1] & ~m_s[2]) : (m_a[0] & ~m_a[1]);
      else tick = gm ? m_g[0] : 1'b1;
      gfall = en & gm & m_g[1] & ~m_g[0];
      nctrl = alias_f(op, m_ctrl, wr_data) & 16'h80B6;
      clr = wn || (wc && nctrl[5:4] != m_ctrl[5:4]);
      hit = (m_ps == ratio_f(m_ctrl[5:4]) - 1);
      inc = tick & hit & ~clr;
      match = inc & ~wn & (m_cnt == m_per);
      fset = gm ? gfall : match;
      if (clr) m_ps <= 0;
      else if (tick) m_ps <= hit ? 0 : m_ps + 1;
      if (wn) m_cnt <= alias_f(op, m_cnt, wr_data);
      else if (inc) m_cnt <= match ? 16'h0 : m_cnt + 16'h1;
      if (wc) m_ctrl <= nctrl;
      if (wp) m_per <= alias_f(op, m_per, wr_data);
      if (fset) m_flag <= 1'b1;
      else if (wf) m_flag <= alias_f(op, {15'h0, m_flag}, wr_data) & 16'h1;
      case (rd_sel)
        2'd0: m_rd <= m_ctrl;
        2'd1: m_rd <= m_cnt;
        2'd2: m_rd <= m_per;
        default: m_rd <= {15'h0, m_flag};
      endcase
      m_rsel <= rd_sel;
      m_s <= {m_s[1:0], ext_clk_pin};
      m_a <= {m_a[0], ext_clk_pin};
      m_g <= {m_g[0], gate_pin};
    end
  end

  // Continuous comparison against the expected state
  always @(negedge clk) begin
    if (!rst) begin
      case (m_rsel)
        2'd0: chk("R2 control readback", rd_data, m_rd);
        2'd1: chk("R4 R5 R6 R7 R8 R9 R12 count", rd_data, m_rd);
        2'd2: chk("R2 period readback", rd_data, m_rd);
        default: chk("R11 flag readback", rd_data, m_rd);
      endcase
      chk("R13 evt_flag", {15'h0, evt_flag}, {15'h0, m_flag});
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [1:0] op, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {s, op}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [15:0] v);
    @(negedge clk); rd_sel = s;
    @(negedge clk); v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_random(input int cycles, input logic [15:0] ctrl_val, input bit ctrl_rand);
    wr(2'd0, 2'd0, ctrl_val);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if ($urandom_range(2) == 0) ext_clk_pin = ~ext_clk_pin;
      if ($urandom_range(5) == 0) gate_pin = ~gate_pin;
      rd_sel = 2'($urandom_range(3));
      if ($urandom_range(29) == 0) begin
        logic [1:0] s;
        s = ctrl_rand ? 2'($urandom_range(3)) : 2'($urandom_range(1, 3));
        wr_en = 1'b1;
        wr_addr = {s, 2'($urandom_range(3))};
        wr_data = (s == 2'd0) ? 16'($urandom) : (16'($urandom) & 16'h003F);
      end else begin
        wr_en = 1'b0;
      end
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    logic [15:0] v, c0, c1;
    void'($urandom(32'd20240611));
    idle(4);
    rst = 1'b0;

    // R1 reset state
    rd_reg(2'd0, v); chk("R1 ctrl after reset", v, 16'h0000);
    rd_reg(2'd1, v); chk("R1 count after reset", v, 16'h0000);
    rd_reg(2'd2, v); chk("R1 period after reset", v, 16'h0000);
    rd_reg(2'd3, v); chk("R1 flag after reset", v, 16'h0000);

    // R2 alias operations and reserved bits
    wr(2'd0, 2'd0, 16'h00B7);
    rd_reg(2'd0, v); chk("R2 write masks reserved bits", v, 16'h00B6);
    wr(2'd0, 2'd1, 16'h0030);
    rd_reg(2'd0, v); chk("R2 clear alias", v, 16'h0086);
    wr(2'd0, 2'd2, 16'h8000);
    rd_reg(2'd0, v); chk("R2 set alias", v, 16'h8086);
    wr(2'd0, 2'd3, 16'h8084);
    rd_reg(2'd0, v); chk("R2 invert alias", v, 16'h0002);

    // R6 zero period
    wr(2'd0, 2'd0, 16'h0000);
    wr(2'd2, 2'd0, 16'h0000);
    wr(2'd1, 2'd0, 16'h0000);
    wr(2'd3, 2'd0, 16'h0000);
    wr(2'd0, 2'd0, 16'h8000);
    idle(10);
    rd_reg(2'd1, v); chk("R6 zero period holds count", v, 16'h0000);
    chk("R6 zero period raises flag", {15'h0, evt_flag}, 16'h0001);

    // R3 disabled timer holds; R11 flag sticky then cleared by alias
    wr(2'd0, 2'd0, 16'h0000);
    wr(2'd1, 2'd0, 16'h0011);
    idle(40);
    rd_reg(2'd1, v); chk("R3 disabled count holds", v, 16'h0011);
    chk("R11 flag still set", {15'h0, evt_flag}, 16'h0001);
    wr(2'd3, 2'd1, 16'h0001);
    rd_reg(2'd3, v); chk("R11 flag cleared by alias", v, 16'h0000);

    // R7 wrap above period
    wr(2'd2, 2'd0, 16'h0005);
    wr(2'd1, 2'd0, 16'hFFFE);
    @(negedge clk); rd_sel = 2'd1;
    wr(2'd0, 2'd0, 16'h8000);
    idle(2);
    chk("R7 count reaches FFFF", rd_data, 16'hFFFF);
    idle(1);
    chk("R7 count wraps to 0", rd_data, 16'h0000);
    chk("R7 no flag on wrap", {15'h0, evt_flag}, 16'h0000);

    // R5 ratio 8 spacing, R12 prescaler restart on count write
    wr(2'd2, 2'd0, 16'hFFFF);
    wr(2'd0, 2'd0, 16'h8010);
    idle(13);
    @(negedge clk); rd_sel = 2'd1;
    wr(2'd1, 2'd0, 16'h0000);
    idle(8);
    chk("R12 no increment before full ratio", rd_data, 16'h0000);
    idle(1);
    chk("R12 increment after full ratio", rd_data, 16'h0001);
    c0 = rd_data; idle(80); c1 = rd_data;
    chk("R5 ratio 8 over 80 cycles", c1 - c0, 16'd10);
    wr(2'd0, 2'd0, 16'h8020);
    idle(3); c0 = rd_data; idle(640); c1 = rd_data;
    chk("R5 ratio 64 over 640 cycles", c1 - c0, 16'd10);

    // R4 internal ratio 1
    wr(2'd0, 2'd0, 16'h8000);
    idle(3); c0 = rd_data; idle(37); c1 = rd_data;
    chk("R4 one tick per cycle", c1 - c0, 16'd37);

    // R9 gated counting and gate-fall flag
    gate_pin = 1'b0;
    wr(2'd0, 2'd0, 16'h0000);
    wr(2'd1, 2'd0, 16'h0000);
    wr(2'd3, 2'd0, 16'h0000);
    wr(2'd0, 2'd0, 16'h8080);
    idle(3);
    rd_reg(2'd1, c0);
    gate_pin = 1'b1; idle(20); gate_pin = 1'b0; idle(5);
    rd_reg(2'd1, c1);
    chk("R9 gated tick count", c1 - c0, 16'd20);
    chk("R9 gate fall sets flag", {15'h0, evt_flag}, 16'h0001);

    // R10 gate ignored with external source; R8 both external paths
    for (int m = 0; m < 2; m++) begin
      ext_clk_pin = 1'b0;
      wr(2'd0, 2'd0, 16'h0000);
      wr(2'd3, 2'd0, 16'h0000);
      wr(2'd1, 2'd0, 16'h0000);
      wr(2'd0, 2'd0, (m == 0) ? 16'h8082 : 16'h8086);
      gate_pin = 1'b1;
      idle(4);
      rd_reg(2'd1, c0);
      for (int k = 0; k < 5; k++) begin
        ext_clk_pin = 1'b1; idle(4);
        ext_clk_pin = 1'b0; idle(4);
      end
      gate_pin = 1'b0;
      idle(6);
      rd_reg(2'd1, c1);
      chk((m == 0) ? "R8 async edge count" : "R8 sync edge count", c1 - c0, 16'd5);
      chk("R10 gate ignored on external source", {15'h0, evt_flag}, 16'h0000);
    end

    // R8 latency: async path two edges, sync path three edges
    for (int m = 0; m < 2; m++) begin
      ext_clk_pin = 1'b0;
      wr(2'd1, 2'd0, 16'h0000);
      wr(2'd0, 2'd0, (m == 0) ? 16'h8002 : 16'h8006);
      @(negedge clk); rd_sel = 2'd1;
      idle(4);
      ext_clk_pin = 1'b1;
      idle((m == 0) ? 2 : 3);
      chk("R8 count unchanged before latency", rd_data, 16'h0000);
      idle(1);
      chk("R8 count changed after latency", rd_data, 16'h0001);
      ext_clk_pin = 1'b0;
    end

    // Random mixed stimulus per mode
    wr(2'd2, 2'd0, 16'h0010);
    run_random(2500, 16'h8000, 1'b0);
    run_random(2500, 16'h8010, 1'b0);
    run_random(2500, 16'h8080, 1'b0);
    run_random(2500, 16'h8090, 1'b0);
    run_random(2500, 16'h8006, 1'b0);
    run_random(2500, 16'h8002, 1'b0);
    run_random(2500, 16'h8086, 1'b0);
    run_random(5000, 16'h8000, 1'b1);

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule